// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block provides three reloading down-counters and one wide free-running up-counter. All four sit behind a plain word-addressed register port with a single-cycle write strobe and a combinational read. Two of the down-counters are 16 bits wide and the third is 32 bits wide. Each has its own load, value, control and clear registers. Each down-counter takes its count enable from one of two clock-enable strobes, a slow one and a fast one. It raises a sticky interrupt every time it passes below zero.

The fourth channel counts up on the fast strobe, is 40 bits wide by default and never interrupts. Software starts it by setting bit 8 of its upper register. Its lower word can be read by itself, so elapsed time is the wrapping difference of two reads. A typical use is a periodic system tick from the first channel and a fine timestamp from the free-running counter.

Register map (word addresses): channel c (c = 0, 1, 2) has load at 8c+0, value at 8c+1, control at 8c+2 and clear at 8c+3. The free-running counter has its lower part at 24 and its upper part at 25. Any other address reads zero and ignores writes.

Top module: `tick_timer_unit`

## Requirements
- R1: After a synchronous reset every register reads zero and all three interrupt outputs are low.
- R2: While a channel is stopped, a load write stores the value and also presets the count. The control register stores only bit 7 (run), bit 6 (periodic reload) and bit 3 (slow strobe when 1, fast when 0), and reads back with all other bits zero.
- R3: A running channel decrements by one on each cycle in which its selected strobe is high. It holds while stopped or while only the other strobe pulses.
- R4: In periodic mode, a tick at count zero reloads the load value and sets the pending flag, so a load value of N gives one interrupt every N+1 ticks.
- R5: With bit 6 clear, a tick at count zero wraps the count to all ones for the channel width and still sets the pending flag.
- R6: irq[c] is the pending flag of channel c. It stays high until any write to that channel's clear register. An underflow in the same cycle as the clear keeps it set.
- R7: A load write while the channel runs leaves the current count untouched, and the new value is used at the next reload.
- R8: Writes to a channel's value register have no effect.
- R9: The free-running counter holds zero while bit 8 of its upper register is clear. Once that bit is set it counts up by one on each fast strobe and carries from the lower part into the upper part. The upper register reads the run bit at bit 8 and the high count bits from bit 0. Writes to the lower register are ignored, and clearing the run bit returns the count to zero.
- R10: Channel 2 uses its full 32-bit width, so a count can decrement across the 16-bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | Slow count-enable strobe, one cycle per tick |
| fast_tick | input | 1 | Fast count-enable strobe, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 3 | Pending interrupt of each down-counting channel |

## Verification
The bench keeps the default 16/16/32 down-counter widths. This lets the one-shot wrap reach 0xFFFF and the 32-bit channel decrement across bit 16. It shrinks the free-running counter to 16 bits with an 8-bit lower part. That brings the carry into the upper register within a few hundred fast ticks, which the 32-bit default lower part would never reach. Random register traffic and random strobes run against a bench model after the directed cases, including a clear and an underflow in the same cycle.

// File: rtl/tick_timer_pkg.sv
// Shared constants and types of the timer unit: register layout,
// control bit positions and the stored control fields.
package tick_timer_pkg;

    localparam int REG_AW      = 5;
    localparam int DW          = 32;
    localparam int NUM_CH      = 3;
    localparam int CH_STRIDE   = 8;

    localparam int OFS_LOAD    = 0;
    localparam int OFS_VAL     = 1;
    localparam int OFS_CTRL    = 2;
    localparam int OFS_CLR     = 3;

    localparam logic [REG_AW-1:0] FREE_LO_ADDR = 5'd24;
    localparam logic [REG_AW-1:0] FREE_HI_ADDR = 5'd25;

    localparam int CB_RUN      = 7;
    localparam int CB_PER      = 6;
    localparam int CB_SLOW     = 3;
    localparam int FREE_RUN_BIT = 8;

    typedef struct packed {
        logic run;
        logic per;
        logic slow;
    } ctrl_t;

    // Word address of register ofs in channel ch.
    function automatic logic [REG_AW-1:0] ch_addr(input int ch, input int ofs);
        return REG_AW'(ch * CH_STRIDE + ofs);
    endfunction

    // Control fields as they appear on the read bus.
    function automatic logic [DW-1:0] ctrl_word(input ctrl_t c);
        logic [DW-1:0] w;
        w          = '0;
        w[CB_RUN]  = c.run;
        w[CB_PER]  = c.per;
        w[CB_SLOW] = c.slow;
        return w;
    endfunction

    // Control fields taken from a write word.
    function automatic ctrl_t ctrl_from(input logic [DW-1:0] w);
        ctrl_t c;
        c.run  = w[CB_RUN];
        c.per  = w[CB_PER];
        c.slow = w[CB_SLOW];
        return c;
    endfunction

endpackage

// File: rtl/tick_down_channel.sv
// One reloading down-counter of width W.
// Assumes: strobes are single-cycle enables in the clk domain; writes to
// load, control and clear arrive as decoded one-cycle pulses.
module tick_down_channel
    import tick_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic          fast_tick,
    input  logic          wr_load,
    input  logic          wr_ctrl,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  count,
    output logic [W-1:0]  load_val,
    output ctrl_t         ctrl,
    output logic          pend
);

    logic tick;
    logic under;

    // Pick the strobe named by the control register and gate it by run.
    assign tick  = ctrl.run && (ctrl.slow ? slow_tick : fast_tick);
    assign under = tick && (count == '0);

    // Load register: any write stores the new reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_val <= '0;
        else if (wr_load) load_val <= wdata[W-1:0];
    end

    // Control register: keeps the run, reload-mode and strobe fields.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_from(wdata);
    end

    // Counter: preset while stopped, reload or wrap on underflow, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (wr_load && !ctrl.run) count <= wdata[W-1:0];
        else if (under)               count <= ctrl.per ? load_val : '1;
        else if (tick)                count <= count - W'(1);
    end

    // Pending flag: set by underflow, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (under)  pend <= 1'b1;
        else if (wr_clr) pend <= 1'b0;
    end

endmodule

// File: rtl/tick_free_counter.sv
// Free-running up-counter of width W with a software run bit.
// Assumes: fast_tick is a one-cycle enable; the count is held at zero
// while the run bit is clear.
module tick_free_counter #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fast_tick,
    input  logic         wr_hi,
    input  logic         run_in,
    output logic         run,
    output logic [W-1:0] count
);

    // Run bit: written through the upper value register.
    always_ff @(posedge clk) begin
        if (!rst_n)     run <= 1'b0;
        else if (wr_hi) run <= run_in;
    end

    // Count: zero while stopped, otherwise step on each fast strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) count <= '0;
        else if (fast_tick) count <= count + W'(1);
    end

endmodule

// File: rtl/tick_timer_unit.sv
// Timer unit top: three reloading down-counters and one free-running
// up-counter behind a word-addressed register port.
// Assumes: FREE_W - FREE_LO_W is between 1 and 8, so the upper count bits
// fit below the run bit of the upper register; FREE_LO_W <= 32.
module tick_timer_unit
    import tick_timer_pkg::*;
#(
    parameter int CH0_W     = 16,
    parameter int CH1_W     = 16,
    parameter int CH2_W     = 32,
    parameter int FREE_W    = 40,
    parameter int FREE_LO_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int FREE_HI_W = FREE_W - FREE_LO_W;

    logic [DW-1:0]     ch_cnt  [NUM_CH];
    logic [DW-1:0]     ch_load [NUM_CH];
    logic [DW-1:0]     ch_ctrl [NUM_CH];
    logic [FREE_W-1:0] free_cnt;
    logic              free_en;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            localparam int CW = (g == 0) ? CH0_W : (g == 1) ? CH1_W : CH2_W;
            logic [CW-1:0] cnt_q;
            logic [CW-1:0] load_q;
            ctrl_t         ctrl_q;
            logic          wr_load, wr_ctrl, wr_clr;

            // Decode the write strobes of this channel.
            assign wr_load = wr_en && (addr == ch_addr(g, OFS_LOAD));
            assign wr_ctrl = wr_en && (addr == ch_addr(g, OFS_CTRL));
            assign wr_clr  = wr_en && (addr == ch_addr(g, OFS_CLR));

            tick_down_channel #(.W(CW)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .slow_tick (slow_tick),
                .fast_tick (fast_tick),
                .wr_load   (wr_load),
                .wr_ctrl   (wr_ctrl),
                .wr_clr    (wr_clr),
                .wdata     (wdata),
                .count     (cnt_q),
                .load_val  (load_q),
                .ctrl      (ctrl_q),
                .pend      (irq[g])
            );

            // Widen channel state to the read bus.
            assign ch_cnt[g]  = DW'(cnt_q);
            assign ch_load[g] = DW'(load_q);
            assign ch_ctrl[g] = ctrl_word(ctrl_q);
        end
    endgenerate

    tick_free_counter #(.W(FREE_W)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .wr_hi     (wr_en && (addr == FREE_HI_ADDR)),
        .run_in    (wdata[FREE_RUN_BIT]),
        .run       (free_en),
        .count     (free_cnt)
    );

    // Read mux: return the addressed register, zero for holes.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ch_addr(c, OFS_LOAD)) rdata = ch_load[c];
            if (addr == ch_addr(c, OFS_VAL))  rdata = ch_cnt[c];
            if (addr == ch_addr(c, OFS_CTRL)) rdata = ch_ctrl[c];
        end
        if (addr == FREE_LO_ADDR) rdata = DW'(free_cnt[FREE_LO_W-1:0]);
        if (addr == FREE_HI_ADDR) begin
            rdata[FREE_HI_W-1:0] = free_cnt[FREE_W-1:FREE_LO_W];
            rdata[FREE_RUN_BIT]  = free_en;
        end
    end

endmodule

// File: rtl/tick_timer_unit_chk.sv
// Property checker for tick_timer_unit, attached by bind below.
module tick_timer_unit_chk
    import tick_timer_pkg::*;
#(
    parameter int FREE_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_tick,
    input logic              fast_tick,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [NUM_CH-1:0] irq,
    input logic [DW-1:0]     ch_cnt [NUM_CH],
    input logic [FREE_W-1:0] free_cnt,
    input logic              free_en
);

    logic was_rst;
    logic hi_wr;

    // Remember that the previous edge saw reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    assign hi_wr = wr_en && (addr == FREE_HI_ADDR);

    // R1: the first cycle after reset shows no interrupt and a zero counter.
    always @(posedge clk) begin
        if (rst_n && was_rst)
            p_reset_quiet_r1: assert (irq == '0 && free_cnt == '0)
                else $error("reset state not quiet");
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_k
            p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                irq[k] && !(wr_en && addr == ch_addr(k, OFS_CLR)) |=> irq[k]);
            p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && addr == ch_addr(k, OFS_CLR) && !slow_tick && !fast_tick
                |=> !irq[k]);
            p_irq_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !irq[k] && !slow_tick && !fast_tick |=> !irq[k]);
            p_count_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !slow_tick && !fast_tick && !(wr_en && addr == ch_addr(k, OFS_LOAD))
                |=> $stable(ch_cnt[k]));
        end
    endgenerate

    p_free_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        free_en && !fast_tick && !hi_wr |=> $stable(free_cnt));
    p_free_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        free_en && fast_tick && !hi_wr |=> free_cnt == $past(free_cnt) + FREE_W'(1));
    p_free_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !free_en && !hi_wr |=> free_cnt == '0);

endmodule

bind tick_timer_unit tick_timer_unit_chk #(.FREE_W(FREE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick),
    .wr_en     (wr_en),
    .addr      (addr),
    .irq       (irq),
    .ch_cnt    (ch_cnt),
    .free_cnt  (free_cnt),
    .free_en   (free_en)
);

// File: tb/tick_timer_unit_bench.sv
// Bench for tick_timer_unit: directed corner cases, then seeded random
// traffic checked against a bench model of the register set.
module tick_timer_unit_bench;

    localparam int FW  = 16;
    localparam int FLW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // Bench model state.
    logic [31:0] m_cnt [3];
    logic [31:0] m_load [3];
    bit          m_run [3];
    bit          m_per [3];
    bit          m_slow [3];
    bit          m_pend [3];
    logic [31:0] m_fcnt;
    bit          m_fen;

    tick_timer_unit #(.FREE_W(FW), .FREE_LO_W(FLW)) u_tick_timer_unit (
        .clk, .rst_n, .slow_tick, .fast_tick, .wr_en, .addr, .wdata, .rdata, .irq
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] wmask(input int c);
        return (c == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        logic [31:0] r = '0;
        for (int c = 0; c < 3; c++) begin
            if (a == 5'(8*c))   r = m_load[c];
            if (a == 5'(8*c+1)) r = m_cnt[c];
            if (a == 5'(8*c+2)) r = {24'b0, m_run[c], m_per[c], 2'b0, m_slow[c], 3'b0};
        end
        if (a == 5'd24) r = m_fcnt & 32'hFF;
        if (a == 5'd25) r = {23'b0, m_fen, m_fcnt[15:8]};
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 0; m_load[c] = 0; m_run[c] = 0;
            m_per[c] = 0; m_slow[c] = 0; m_pend[c] = 0;
        end
        m_fcnt = 0; m_fen = 0;
    endtask

    task automatic model_step(input bit w, input logic [4:0] a, input logic [31:0] d,
                              input bit s, input bit f);
        for (int c = 0; c < 3; c++) begin
            bit tk, und;
            logic [31:0] nc;
            tk  = m_run[c] && (m_slow[c] ? s : f);
            und = tk && (m_cnt[c] == 0);
            nc  = m_cnt[c];
            if (und)     nc = m_per[c] ? m_load[c] : wmask(c);
            else if (tk) nc = (m_cnt[c] - 1) & wmask(c);
            if (w && a == 5'(8*c)) begin
                if (!m_run[c]) nc = d & wmask(c);
                m_load[c] = d & wmask(c);
            end
            if (und) m_pend[c] = 1;
            else if (w && a == 5'(8*c+3)) m_pend[c] = 0;
            if (w && a == 5'(8*c+2)) begin
                m_run[c] = d[7]; m_per[c] = d[6]; m_slow[c] = d[3];
            end
            m_cnt[c] = nc;
        end
        if (!m_fen)  m_fcnt = 0;
        else if (f)  m_fcnt = (m_fcnt + 1) & 32'hFFFF;
        if (w && a == 5'd25) m_fen = d[8];
    endtask

    // One clock cycle with optional write and strobes; checks irq after it.
    task automatic cycle(input bit w, input logic [4:0] a, input logic [31:0] d,
                         input bit s, input bit f);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; slow_tick = s; fast_tick = f;
        @(posedge clk);
        #1;
        wr_en = 0; slow_tick = 0; fast_tick = 0;
        model_step(w, a, d, s, f);
        check("R6 irq equals pending", {29'b0, irq},
              {29'b0, m_pend[2], m_pend[1], m_pend[0]});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cycle(1, a, d, 0, 0);
    endtask

    task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int first;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        check("R1 irq", {29'b0, irq}, 0);
        for (int a = 0; a < 26; a++) rd("R1 reset read", 5'(a), 0);

        // R2: preset while stopped, control readback
        wr(2, 32'h48);
        wr(0, 5);
        rd("R2 preset value", 1, 5);
        rd("R2 load readback", 0, 5);
        rd("R2 ctrl readback", 2, 32'h48);
        wr(10, 32'h7F);
        rd("R2 ctrl masks bits", 10, 32'h48);

        // R8: value register write ignored
        wr(1, 32'h1234);
        rd("R8 value write ignored", 1, 5);

        // R3: count on selected strobe only
        wr(2, 32'hC8);
        repeat (3) cycle(0, 0, 0, 0, 1);
        rd("R3 other strobe no count", 1, 5);
        repeat (3) cycle(0, 0, 0, 1, 0);
        rd("R3 decrement", 1, 2);

        // R4: reload and interrupt
        repeat (2) cycle(0, 0, 0, 1, 0);
        rd("R4 at zero", 1, 0);
        check("R4 no irq at zero", {31'b0, irq[0]}, 0);
        cycle(0, 0, 0, 1, 0);
        rd("R4 reload value", 1, 5);
        check("R4 irq on underflow", {31'b0, irq[0]}, 1);

        // R6: hold then clear
        repeat (3) cycle(0, 0, 0, 0, 0);
        check("R6 held", {31'b0, irq[0]}, 1);
        wr(3, 32'hDEAD);
        check("R6 cleared", {31'b0, irq[0]}, 0);

        // R4: period is load + 1 ticks
        first = 0;
        for (int i = 1; i <= 8; i++) begin
            cycle(0, 0, 0, 1, 0);
            if (irq[0] && first == 0) first = i;
        end
        check("R4 period", first, 6);
        wr(3, 0);

        // R6: clear in the underflow cycle keeps pending set
        while (m_cnt[0] != 0) cycle(0, 0, 0, 1, 0);
        rd("R6 reached zero", 1, 0);
        cycle(1, 3, 0, 1, 0);
        check("R6 underflow beats clear", {31'b0, irq[0]}, 1);
        wr(3, 0);

        // R7: load write while running
        rd("R7 count before", 1, 5);
        wr(0, 9);
        rd("R7 count untouched", 1, 5);
        rd("R7 load stored", 0, 9);
        repeat (6) cycle(0, 0, 0, 1, 0);
        rd("R7 new reload", 1, 9);

        // R5: one-shot wrap to all ones
        wr(8, 2);
        wr(10, 32'h88);
        repeat (3) cycle(0, 0, 0, 1, 0);
        rd("R5 wrap all ones", 9, 32'hFFFF);
        check("R5 irq", {31'b0, irq[1]}, 1);
        cycle(0, 0, 0, 1, 0);
        rd("R5 continues", 9, 32'hFFFE);

        // R10: 32-bit channel crosses bit 16
        wr(16, 32'h0001_0000);
        wr(18, 32'h80);
        cycle(0, 0, 0, 1, 0);
        rd("R3 fast-select ignores slow", 17, 32'h0001_0000);
        cycle(0, 0, 0, 0, 1);
        rd("R10 wide decrement", 17, 32'h0000_FFFF);
        rd("R10 wide load", 16, 32'h0001_0000);

        // R9: free-running counter
        repeat (2) cycle(0, 0, 0, 0, 1);
        rd("R9 stopped at zero", 24, 0);
        wr(25, 32'h100);
        rd("R9 run bit", 25, 32'h100);
        repeat (300) cycle(0, 0, 0, 0, 1);
        rd("R9 low part", 24, 44);
        rd("R9 carry into high", 25, 32'h101);
        wr(24, 32'hAA);
        rd("R9 low write ignored", 24, 44);
        wr(25, 0);
        cycle(0, 0, 0, 0, 0);
        rd("R9 stop clears", 24, 0);
        rd("R9 high after stop", 25, 0);

        // Random traffic against the model
        for (int it = 0; it < 600; it++) begin
            int op, ch;
            logic [31:0] ctl;
            bit s, f;
            op = $urandom % 7;
            ch = $urandom % 3;
            s  = ($urandom % 2) == 1;
            f  = ($urandom % 3) == 0;
            case ($urandom % 6)
                0: ctl = 32'h48;
                1: ctl = 32'hC8;
                2: ctl = 32'h80;
                3: ctl = 32'h88;
                4: ctl = 32'hC0;
                default: ctl = 32'h00;
            endcase
            case (op)
                0: cycle(1, 5'(8*ch), $urandom % 6, s, f);
                1: cycle(1, 5'(8*ch+2), ctl, s, f);
                2: cycle(1, 5'(8*ch+3), $urandom, s, f);
                3: cycle(1, 5'(8*ch+1), $urandom, s, f);
                4: cycle(1, 5'd25, {23'b0, 1'($urandom % 2), 8'b0}, s, f);
                default: cycle(0, 0, 0, s, f);
            endcase
            begin
                logic [4:0] ra;
                ra = ((it % 4) == 3) ? 5'(24 + $urandom % 2) : 5'(8*($urandom % 3) + $urandom % 3);
                rd("R3 R4 R5 R7 R9 random read", ra, exp_read(ra));
            end
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule